// File: doc/BRIEF.md
# Single-Slope Rundown Converter Controller

This block sequences the digital side of an integrating converter that digitizes a demodulated sensor current. A start request runs one conversion. The integrator is first cleared for a programmable number of clocks. It then accumulates the input for a fixed, programmed window. After the window, a constant current discharges the integrator, and the block counts clocks until the comparator reports a return to baseline. That count is the 10-bit result. The result is shifted out serially, most significant bit first, and a done pulse closes the conversion.

The block also owns a 9-bit offset-trim code for the current DAC of the sensing chain. A calibration runs only when the user requests it. The integrator input is expected to be nulled during calibration. The search runs nine conversions and decides one trim bit per conversion. The final code stays in force until the next calibration. The analog integrator, comparator and DAC are outside this block.

Top module: `slope_adc_ctrl`

## Requirements
- R1: A start request accepted in idle holds the integrator reset high for max(rstLen,1) clocks, then holds integrate enable high for max(intLen,1) clocks. At most one of integrator reset, integrate enable, discharge enable and serial strobe is high in any cycle.
- R2: Discharge enable rises in the clock right after integrate enable falls. The result equals the number of discharge cycles in which the comparator was sampled low before the first cycle in which it is sampled high. Discharge enable is therefore high for result+1 cycles.
- R3: If the comparator has not tripped by count 1023, the result saturates at 1023 and the overflow output goes high. Overflow is cleared when the next conversion is started.
- R4: After each conversion, the result leaves on serData as 10 strobes on consecutive clocks, one bit per strobe, most significant bit first.
- R5: Done is a single-cycle pulse in the clock after the last serial strobe, or after the final step of a calibration.
- R6: Start and calibration requests that arrive while a conversion or calibration is in progress are ignored. The running operation's result and trim code are unaffected.
- R7: A calibration request runs 9 steps from trim bit 8 down to bit 0. Each step sets its trial bit and runs one conversion. The bit is kept only if that result is above 511. No serial strobes occur during calibration.
- R8: The trim code is 0 after reset. It changes only during calibration, and conversions leave it unchanged.
- R9: When start and calibration requests arrive in the same idle cycle, the calibration runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request one conversion |
| calReq | input | 1 | Request an offset calibration |
| cmpTrip | input | 1 | Comparator: high when the integrator is back at baseline |
| rstLen | input | 8 | Integrator reset hold length in clocks (0 acts as 1) |
| intLen | input | 16 | Integration window length in clocks (0 acts as 1) |
| intRst | output | 1 | Integrator reset |
| intEn | output | 1 | Integrate enable |
| dischEn | output | 1 | Constant-current discharge enable |
| dacCode | output | 9 | Offset-trim code for the current DAC |
| serData | output | 1 | Serial result bit, valid while serStrobe is high |
| serStrobe | output | 1 | Serial bit strobe |
| done | output | 1 | End-of-operation pulse |
| overflow | output | 1 | Last result saturated |

## Verification
Every cycle, the assertions check that the four phase outputs never overlap and that discharge directly follows integration. They also check that a result is only taken without a comparator trip at full count, that done comes straight after a strobe, that no strobe appears during calibration, and that the trim code does not move outside calibration. The exact phase lengths, the counted value and its bit order on the serial line, saturation and clearing of overflow, the converged trim code, and the handling of late or simultaneous requests are end-to-end properties. Only the bench's scenarios show them, using a behavioural comparator whose trip point the bench sets or derives from the trim code.

// File: rtl/slope_adc_pkg.sv
package slope_adc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_INT,
    ST_DIS,
    ST_SHF,
    ST_FIN
  } adc_state_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic tmrLoadRst;
    logic tmrLoadInt;
    logic tmrDec;
    logic cntClr;
    logic cntInc;
    logic latchRes;
    logic shStep;
    logic ovfClr;
    logic calInit;
    logic calDecide;
  } adc_stb_t;

endpackage

// File: rtl/slope_adc_dp.sv
module slope_adc_dp
  import slope_adc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DAC_W = 9,
  parameter int TMR_W = 16,
  parameter int RST_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  adc_stb_t         stb,
  input  logic             cmpTrip,
  input  logic [RST_W-1:0] rstLen,
  input  logic [TMR_W-1:0] intLen,
  output logic             tmrZero,
  output logic             cntHit,
  output logic             shLast,
  output logic             bitZero,
  output logic [DAC_W-1:0] dacCode,
  output logic             serData,
  output logic             overflow
);
  localparam int BIT_W = (DAC_W > 1) ? $clog2(DAC_W) : 1;
  localparam int SH_W  = $clog2(CNT_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MID     = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [DAC_W-1:0] DAC_TOP = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic [DAC_W-1:0] DAC_ONE = {{(DAC_W-1){1'b0}}, 1'b1};

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shReg;
  logic [SH_W-1:0]  bitCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [CNT_W-1:0] resNext;
  logic [DAC_W-1:0] bitMask;
  logic [DAC_W-1:0] dacAfter;
  logic [TMR_W-1:0] rstExt;

  assign rstExt  = {{(TMR_W-RST_W){1'b0}}, rstLen};
  assign tmrZero = (tmr == '0);
  assign cntHit  = (cnt == CNT_MAX);
  assign shLast  = (bitCnt == '0);
  assign bitZero = (bitIdx == '0);
  assign serData = shReg[CNT_W-1];
  assign resNext = cmpTrip ? cnt : CNT_MAX;
  assign bitMask = DAC_ONE << bitIdx;

  always_comb begin
    dacAfter = dacCode;
    if (!(resNext > MID)) dacAfter = dacAfter & ~bitMask;
    if (bitIdx != '0)     dacAfter = dacAfter | (bitMask >> 1);
  end

  // phase timer: loaded with length-1, zero length treated as one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmr <= '0;
    else if (stb.tmrLoadRst) tmr <= (rstExt == '0) ? '0 : rstExt - 1'b1;
    else if (stb.tmrLoadInt) tmr <= (intLen == '0) ? '0 : intLen - 1'b1;
    else if (stb.tmrDec)     tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (stb.cntClr) cnt <= '0;
    else if (stb.cntInc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      overflow <= 1'b0;
    end else begin
      if (stb.ovfClr) overflow <= 1'b0;
      if (stb.latchRes) begin
        shReg    <= resNext;
        bitCnt   <= SH_W'(CNT_W-1);
        overflow <= !cmpTrip;
      end else if (stb.shStep) begin
        shReg  <= {shReg[CNT_W-2:0], 1'b0};
        bitCnt <= bitCnt - 1'b1;
      end
    end
  end

  // successive-approximation trim search
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode <= '0;
      bitIdx  <= '0;
    end else if (stb.calInit) begin
      dacCode <= DAC_TOP;
      bitIdx  <= BIT_W'(DAC_W-1);
    end else if (stb.calDecide) begin
      dacCode <= dacAfter;
      if (bitIdx != '0) bitIdx <= bitIdx - 1'b1;
    end
  end

  // R3: a result taken without a trip must be at full count
  assert_sat_at_max_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchRes && !cmpTrip) |-> cntHit);

endmodule

// File: rtl/slope_adc_ctl.sv
module slope_adc_ctl
  import slope_adc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     calReq,
  input  logic     cmpTrip,
  input  logic     tmrZero,
  input  logic     cntHit,
  input  logic     shLast,
  input  logic     bitZero,
  output adc_stb_t stb,
  output logic     intRst,
  output logic     intEn,
  output logic     dischEn,
  output logic     serStrobe,
  output logic     done,
  output logic     calActive
);
  adc_state_t state, stateNext;
  logic calMode, calModeNext;
  logic finish;

  assign finish = cmpTrip || cntHit;

  always_comb begin
    stb         = '0;
    stateNext   = state;
    calModeNext = calMode;
    unique case (state)
      ST_IDLE: begin
        if (calReq) begin
          stb.calInit    = 1'b1;
          stb.tmrLoadRst = 1'b1;
          calModeNext    = 1'b1;
          stateNext      = ST_RST;
        end else if (startReq) begin
          stb.ovfClr     = 1'b1;
          stb.tmrLoadRst = 1'b1;
          calModeNext    = 1'b0;
          stateNext      = ST_RST;
        end
      end
      ST_RST: begin
        if (tmrZero) begin
          stb.tmrLoadInt = 1'b1;
          stateNext      = ST_INT;
        end else stb.tmrDec = 1'b1;
      end
      ST_INT: begin
        if (tmrZero) begin
          stb.cntClr = 1'b1;
          stateNext  = ST_DIS;
        end else stb.tmrDec = 1'b1;
      end
      ST_DIS: begin
        if (finish) begin
          if (calMode) begin
            stb.calDecide = 1'b1;
            if (bitZero) stateNext = ST_FIN;
            else begin
              stb.tmrLoadRst = 1'b1;
              stateNext      = ST_RST;
            end
          end else begin
            stb.latchRes = 1'b1;
            stateNext    = ST_SHF;
          end
        end else stb.cntInc = 1'b1;
      end
      ST_SHF: begin
        stb.shStep = 1'b1;
        if (shLast) stateNext = ST_FIN;
      end
      ST_FIN: begin
        calModeNext = 1'b0;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      calMode <= 1'b0;
    end else begin
      state   <= stateNext;
      calMode <= calModeNext;
    end
  end

  assign intRst    = (state == ST_RST);
  assign intEn     = (state == ST_INT);
  assign dischEn   = (state == ST_DIS);
  assign serStrobe = (state == ST_SHF);
  assign done      = (state == ST_FIN);
  assign calActive = calMode && (state != ST_IDLE);

  assert_phase_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intRst, intEn, dischEn, serStrobe}));

  assert_disch_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intEn) |-> dischEn);

  assert_done_after_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !calMode) |-> $past(serStrobe));

  assert_cal_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    calActive |-> !serStrobe);

endmodule

// File: rtl/slope_adc_ctrl.sv
module slope_adc_ctrl
  import slope_adc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DAC_W = 9,
  parameter int TMR_W = 16,
  parameter int RST_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             calReq,
  input  logic             cmpTrip,
  input  logic [RST_W-1:0] rstLen,
  input  logic [TMR_W-1:0] intLen,
  output logic             intRst,
  output logic             intEn,
  output logic             dischEn,
  output logic [DAC_W-1:0] dacCode,
  output logic             serData,
  output logic             serStrobe,
  output logic             done,
  output logic             overflow
);
  adc_stb_t stb;
  logic tmrZero, cntHit, shLast, bitZero, calActive;

  slope_adc_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .calReq(calReq),
    .cmpTrip(cmpTrip), .tmrZero(tmrZero), .cntHit(cntHit),
    .shLast(shLast), .bitZero(bitZero), .stb(stb),
    .intRst(intRst), .intEn(intEn), .dischEn(dischEn),
    .serStrobe(serStrobe), .done(done), .calActive(calActive)
  );

  slope_adc_dp #(.CNT_W(CNT_W), .DAC_W(DAC_W), .TMR_W(TMR_W), .RST_W(RST_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpTrip(cmpTrip),
    .rstLen(rstLen), .intLen(intLen), .tmrZero(tmrZero),
    .cntHit(cntHit), .shLast(shLast), .bitZero(bitZero),
    .dacCode(dacCode), .serData(serData), .overflow(overflow)
  );

  // R8: trim code frozen whenever no calibration is running
  assert_trim_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    !calActive |-> $stable(dacCode));

endmodule

// File: tb/slope_adc_ctrl_bench.sv
module slope_adc_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic calReq = 1'b0;
  logic cmpTrip = 1'b0;
  logic [7:0] rstLen = 8'd2;
  logic [15:0] intLen = 16'd3;
  logic intRst, intEn, dischEn, serData, serStrobe, done, overflow;
  logic [8:0] dacCode;

  int total = 0;
  int bad = 0;

  // behavioural comparator and monitor state
  int target = 0;
  bit calModel = 1'b0;
  int dcount = 0;
  int nRst, nInt, nDis, nDisRuns, nStb, nDone, overlap;
  logic [9:0] serWord;
  logic prevDis = 1'b0;

  always #5 clk = ~clk;

  slope_adc_ctrl u_slope_adc_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .calReq(calReq),
    .cmpTrip(cmpTrip), .rstLen(rstLen), .intLen(intLen),
    .intRst(intRst), .intEn(intEn), .dischEn(dischEn),
    .dacCode(dacCode), .serData(serData), .serStrobe(serStrobe),
    .done(done), .overflow(overflow)
  );

  function automatic int trip_point();
    int t;
    if (calModel) begin
      t = 600 - int'(dacCode);
      if (t < 0) t = 0;
      return t;
    end
    return target;
  endfunction

  always @(negedge clk) begin
    if (dischEn) begin
      cmpTrip <= (dcount >= trip_point());
      dcount = dcount + 1;
    end else begin
      cmpTrip <= 1'b0;
      dcount = 0;
    end
  end

  always @(posedge clk) begin
    if (intRst) nRst++;
    if (intEn) nInt++;
    if (dischEn) nDis++;
    if (dischEn && !prevDis) nDisRuns++;
    prevDis <= dischEn;
    if (serStrobe) begin
      nStb++;
      serWord <= {serWord[8:0], serData};
    end
    if (done) nDone++;
    if ((int'(intRst) + int'(intEn) + int'(dischEn) + int'(serStrobe)) > 1) overlap++;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nRst = 0; nInt = 0; nDis = 0; nDisRuns = 0; nStb = 0; nDone = 0; overlap = 0;
  endtask

  task automatic pulse(bit s, bit c);
    @(negedge clk);
    startReq = s; calReq = c;
    @(negedge clk);
    startReq = 0; calReq = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int maxi(int a, int b); return (a > b) ? a : b; endfunction

  // one conversion, optional late requests while busy
  task automatic run_conv(string tag, int r, int i, int tgt, bit lateReq);
    int expRes;
    logic [8:0] dacBefore;
    dacBefore = dacCode;
    rstLen = 8'(r); intLen = 16'(i); target = tgt; calModel = 0;
    expRes = (tgt > 1023) ? 1023 : tgt;
    clear_mon();
    pulse(1, 0);
    if (lateReq) begin
      while (!intEn) @(negedge clk);
      startReq = 1; calReq = 1;
      @(negedge clk);
      startReq = 0; calReq = 0;
    end
    wait_done();
    check({tag, " R1 reset hold"}, nRst, maxi(r, 1));
    check({tag, " R1 integrate window"}, nInt, maxi(i, 1));
    check({tag, " R1 overlap"}, overlap, 0);
    check({tag, " R2 discharge cycles"}, nDis, expRes + 1);
    check({tag, " R4 serial value"}, int'(serWord), expRes);
    check({tag, " R4 strobes"}, nStb, 10);
    check({tag, " R5 done pulses"}, nDone, 1);
    check({tag, " R3 overflow"}, int'(overflow), (tgt > 1023) ? 1 : 0);
    check({tag, " R8 trim unchanged"}, int'(dacCode), int'(dacBefore));
    if (lateReq) begin
      repeat (5) @(negedge clk);
      check({tag, " R6 no restart"}, nRst, maxi(r, 1));
    end
  endtask

  task automatic run_cal(string tag, bit withStart);
    int code;
    int res;
    code = 0;
    for (int b = 8; b >= 0; b--) begin
      res = 600 - (code | (1 << b));
      if (res < 0) res = 0;
      if (res > 511) code = code | (1 << b);
    end
    rstLen = 8'd2; intLen = 16'd3; calModel = 1;
    clear_mon();
    pulse(withStart, 1);
    wait_done();
    calModel = 0;
    check({tag, " R7 trim code"}, int'(dacCode), code);
    check({tag, " R7 steps"}, nDisRuns, 9);
    check({tag, " R7 no strobes"}, nStb, 0);
    check({tag, " R5 done pulses"}, nDone, 1);
  endtask

  task automatic test_reset();
    check("R8 reset trim", int'(dacCode), 0);
    check("R1 reset outputs", int'({intRst, intEn, dischEn, serStrobe, done, overflow}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1;
    @(negedge clk);
    run_conv("basic", 2, 3, 37, 0);
    run_conv("zero", 0, 0, 0, 0);
    run_conv("pattern", 5, 20, 682, 0);
    run_conv("max", 1, 1, 1023, 0);
    run_conv("sat", 3, 4, 5000, 0);
    run_conv("clear", 1, 2, 341, 0);
    run_conv("late", 4, 6, 100, 1);
    run_cal("cal", 0);
    run_conv("postcal", 2, 2, 512, 0);
    run_cal("both R9", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule